// File: doc/BRIEF.md
# Quadrature Position Decoder with Home Reload

This block turns two out-of-phase encoder signals into a signed 32-bit position. Each accepted level change on either phase moves the count by exactly one, up or down according to which phase leads. A third input marks a home position. When the selected home event occurs, the count is reloaded from a preset value and a sticky flag is raised, which can drive an interrupt.

All three inputs are synchronized and then filtered. A level change must persist for a programmable number of cycles before it passes the filter. A second stage then drops any edge whose level has already reverted by the cycle in which the edge is serviced. Each counted edge stamps the current value of one of two free-running timebases. The host can capture that stamp and the current time in the same cycle, so that it can interpolate between slow edges. The host loads the preset through a write strobe. It can load the count from the preset with a command or write the count directly.

Top module: `quad_home_decoder`

## Requirements
- R1: With the filter length at 0, a phase level change presented at the pins is reflected in `pos` on the fourth rising clock edge after the one that samples it. A change of phase A counts up when the new A level differs from the accepted B level. A change of phase B counts up when the new B level equals the accepted A level. Every other single-phase change counts down by one, and the count wraps in two's complement.
- R2: With `cfg_swap`=0, `in_p0` is phase A and `in_p1` is phase B. With `cfg_swap`=1 the roles are exchanged.
- R3: `preset_wr` loads `wr_data` into the preset register. A `cmd_init` pulse loads `pos` from the preset on the next clock edge.
- R4: With `cfg_filt_len`=N, a level change on a synchronized input is passed on only after it has held for N+1 consecutive cycles. A shorter excursion is discarded.
- R5: If a filtered level reverts in the cycle after it changed, no count results. A filtered excursion of two or more cycles is counted on both edges, for a net change of zero.
- R6: If both phases are accepted as changed in the same cycle, `pos` is left unchanged and `phase_err` is set. `phase_err` stays set until `status_clr`.
- R7: On each counted edge, `last_edge_ts` takes the selected timebase. `cfg_tb_sel`=0 selects a 16-bit time that advances every cycle. `cfg_tb_sel`=1 selects one that advances once every TB1_DIV cycles.
- R8: A `cmd_get_time` pulse copies `last_edge_ts` into `snap_edge_ts` and the current selected time into `snap_now_ts`, both on the same clock edge.
- R9: `cfg_home_mode` selects the home event: 00 is a rising filtered home edge, 01 is a falling edge, and 1x is either edge. On that event `pos` is reloaded from the preset.
- R10: A home event sets `home_flag`, which stays set until `status_clr`. `irq` is high exactly when `home_flag` and `cfg_irq_en` are both high. A home event in the same cycle as `status_clr` leaves the flag set.
- R11: Within one cycle, the load sources of `pos` take effect in this order, highest first: `pos_wr`, then `cmd_init`, then the home reload, then counting.
- R12: After reset, `pos`, the preset, all timestamps, `home_flag`, `phase_err` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_p0 | input | 1 | Encoder input 0 (asynchronous) |
| in_p1 | input | 1 | Encoder input 1 (asynchronous) |
| in_home | input | 1 | Home marker input (asynchronous) |
| cfg_swap | input | 1 | Exchange the phase A and phase B roles |
| cfg_tb_sel | input | 1 | Timebase select: 0 fast, 1 divided |
| cfg_home_mode | input | 2 | Home event select |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_filt_len | input | FILT_W | Filter hold length N |
| preset_wr | input | 1 | Load the preset from `wr_data` |
| pos_wr | input | 1 | Load the position from `wr_data` |
| wr_data | input | CNT_W | Host write data |
| cmd_init | input | 1 | Load the position from the preset |
| cmd_get_time | input | 1 | Capture the time pair |
| status_clr | input | 1 | Clear `home_flag` and `phase_err` |
| pos | output | CNT_W | Signed position count |
| last_edge_ts | output | TS_W | Time of the last counted edge |
| snap_edge_ts | output | TS_W | Captured last-edge time |
| snap_now_ts | output | TS_W | Captured current time |
| home_flag | output | 1 | Sticky home event status |
| phase_err | output | 1 | Sticky simultaneous-phase error |
| irq | output | 1 | Interrupt request |

## Verification
A pin change reaches `pos` on the fourth clock edge after it is sampled, plus N edges for a filter length of N. A home change takes effect one edge earlier than a phase change. Host writes, commands and the time capture take effect on the very next edge. The bench runs a behavioural reference that advances once per clock edge and is compared with every output at the following falling edge, so each result is checked in the cycle it is due. Directed checks are taken only after waiting well beyond these latencies. One case delays the home input by one cycle against a phase change so that the reload and the count land on the same edge.

// File: rtl/quad_home_decoder.sv
module quad_home_decoder #(
  parameter int CNT_W   = 32,
  parameter int TS_W    = 16,
  parameter int FILT_W  = 4,
  parameter int TB1_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_p0,
  input  logic              in_p1,
  input  logic              in_home,
  input  logic              cfg_swap,
  input  logic              cfg_tb_sel,
  input  logic [1:0]        cfg_home_mode,
  input  logic              cfg_irq_en,
  input  logic [FILT_W-1:0] cfg_filt_len,
  input  logic              preset_wr,
  input  logic              pos_wr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cmd_init,
  input  logic              cmd_get_time,
  input  logic              status_clr,
  output logic [CNT_W-1:0]  pos,
  output logic [TS_W-1:0]   last_edge_ts,
  output logic [TS_W-1:0]   snap_edge_ts,
  output logic [TS_W-1:0]   snap_now_ts,
  output logic              home_flag,
  output logic              phase_err,
  output logic              irq
);
  localparam int NIN   = 3;
  localparam int PRE_W = (TB1_DIV > 1) ? $clog2(TB1_DIV) : 1;

  logic [NIN-1:0]    s1, s2, flt, flt_d, flt_dd;
  logic [FILT_W-1:0] fcnt [NIN];
  logic [1:0]        acc;
  logic [CNT_W-1:0]  preset_q;
  logic [TS_W-1:0]   tb0, tb1;
  logic [PRE_W-1:0]  pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; flt <= '0; flt_d <= '0; flt_dd <= '0;
      for (int i = 0; i < NIN; i++) fcnt[i] <= '0;
    end else begin
      s1 <= {in_home, in_p1, in_p0};
      s2 <= s1;
      flt_d  <= flt;
      flt_dd <= flt_d;
      for (int i = 0; i < NIN; i++) begin
        if (s2[i] != flt[i]) begin
          if (fcnt[i] >= cfg_filt_len) begin
            flt[i]  <= s2[i];
            fcnt[i] <= '0;
          end else begin
            fcnt[i] <= fcnt[i] + FILT_W'(1);
          end
        end else begin
          fcnt[i] <= '0;
        end
      end
    end
  end

  logic [1:0] svc_p;
  assign svc_p[0] = (flt_d[0] != flt_dd[0]) && (flt[0] != acc[0]);
  assign svc_p[1] = (flt_d[1] != flt_dd[1]) && (flt[1] != acc[1]);

  logic svc_a, svc_b, lvl_a, lvl_b, acc_a, acc_b, both, step, up;
  assign svc_a = cfg_swap ? svc_p[1] : svc_p[0];
  assign svc_b = cfg_swap ? svc_p[0] : svc_p[1];
  assign lvl_a = cfg_swap ? flt[1]   : flt[0];
  assign lvl_b = cfg_swap ? flt[0]   : flt[1];
  assign acc_a = cfg_swap ? acc[1]   : acc[0];
  assign acc_b = cfg_swap ? acc[0]   : acc[1];
  assign both  = svc_a & svc_b;
  assign step  = svc_a ^ svc_b;
  assign up    = svc_a ? (lvl_a != acc_b) : (lvl_b == acc_a);

  logic h_rise, h_fall, home_evt;
  assign h_rise   = flt[2] & ~flt_d[2];
  assign h_fall   = ~flt[2] & flt_d[2];
  assign home_evt = cfg_home_mode[1] ? (h_rise | h_fall)
                  : (cfg_home_mode[0] ? h_fall : h_rise);

  logic [TS_W-1:0] cur_ts;
  assign cur_ts = cfg_tb_sel ? tb1 : tb0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb0 <= '0; tb1 <= '0; pre <= '0;
    end else begin
      tb0 <= tb0 + TS_W'(1);
      if (pre == PRE_W'(TB1_DIV - 1)) begin
        pre <= '0;
        tb1 <= tb1 + TS_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; pos <= '0; preset_q <= '0; last_edge_ts <= '0;
      snap_edge_ts <= '0; snap_now_ts <= '0; home_flag <= 1'b0; phase_err <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) if (svc_p[i]) acc[i] <= flt[i];
      if (preset_wr) preset_q <= wr_data;
      if (pos_wr)                    pos <= wr_data;
      else if (cmd_init || home_evt) pos <= preset_q;
      else if (step)                 pos <= up ? pos + CNT_W'(1) : pos - CNT_W'(1);
      if (step) last_edge_ts <= cur_ts;
      if (cmd_get_time) begin
        snap_edge_ts <= last_edge_ts;
        snap_now_ts  <= cur_ts;
      end
      if (home_evt)        home_flag <= 1'b1;
      else if (status_clr) home_flag <= 1'b0;
      if (both)            phase_err <= 1'b1;
      else if (status_clr) phase_err <= 1'b0;
    end
  end

  assign irq = home_flag & cfg_irq_en;

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pos_wr) && !$past(cmd_init) && !$past(home_evt)) |->
      (pos == $past(pos) || pos == $past(pos) + CNT_W'(1) || pos == $past(pos) - CNT_W'(1)));
  p_init_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_init) && !$past(pos_wr)) |-> pos == $past(preset_q));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_err && !status_clr) |=> phase_err);
  p_snap_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_get_time |=> (snap_edge_ts == $past(last_edge_ts) && snap_now_ts == $past(cur_ts)));
  p_home_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (home_evt && !pos_wr) |=> pos == $past(preset_q));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (home_flag && !status_clr) |=> home_flag);
  p_wr_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pos_wr |=> pos == $past(wr_data));
endmodule

// File: tb/test_quad_home_decoder.sv
module test_quad_home_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int TB1_DIV = 4;

  logic clk = 0, rst_n = 0;
  logic in_p0 = 0, in_p1 = 0, in_home = 0;
  logic cfg_swap = 0, cfg_tb_sel = 0, cfg_irq_en = 0;
  logic [1:0] cfg_home_mode = 2'b00;
  logic [3:0] cfg_filt_len = 4'd0;
  logic preset_wr = 0, pos_wr = 0, cmd_init = 0, cmd_get_time = 0, status_clr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] pos;
  logic [15:0] last_edge_ts, snap_edge_ts, snap_now_ts;
  logic home_flag, phase_err, irq;

  quad_home_decoder #(.TB1_DIV(TB1_DIV)) i_quad_home_decoder (
    .clk(clk), .rst_n(rst_n), .in_p0(in_p0), .in_p1(in_p1), .in_home(in_home),
    .cfg_swap(cfg_swap), .cfg_tb_sel(cfg_tb_sel), .cfg_home_mode(cfg_home_mode),
    .cfg_irq_en(cfg_irq_en), .cfg_filt_len(cfg_filt_len), .preset_wr(preset_wr),
    .pos_wr(pos_wr), .wr_data(wr_data), .cmd_init(cmd_init), .cmd_get_time(cmd_get_time),
    .status_clr(status_clr), .pos(pos), .last_edge_ts(last_edge_ts),
    .snap_edge_ts(snap_edge_ts), .snap_now_ts(snap_now_ts), .home_flag(home_flag),
    .phase_err(phase_err), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string req = "R12";
  int qs = 0;

  // behavioural reference state
  int hist [3][$];
  int run [3];
  int lvl [3], lvl1 [3], lvl2 [3];
  int ok [2];
  int m_pos, m_preset, m_last, m_snap_e, m_snap_n, m_t0, m_t1, m_div;
  bit m_flag, m_err;

  task automatic chk(string r, string what, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      hist[i] = {0, 0}; run[i] = 0; lvl[i] = 0; lvl1[i] = 0; lvl2[i] = 0;
    end
    ok[0] = 0; ok[1] = 0;
    m_pos = 0; m_preset = 0; m_last = 0; m_snap_e = 0; m_snap_n = 0;
    m_t0 = 0; m_t1 = 0; m_div = 0; m_flag = 0; m_err = 0;
  endtask

  task automatic model_step();
    int raw [3];
    int seen [3];
    int nlvl [3];
    bit acc_ch [2];
    int ia, ib, now, hev;
    raw[0] = in_p0; raw[1] = in_p1; raw[2] = in_home;
    for (int i = 0; i < 3; i++) begin
      seen[i] = hist[i][0];
      nlvl[i] = lvl[i];
      if (seen[i] != lvl[i]) begin
        if (run[i] >= cfg_filt_len) begin nlvl[i] = seen[i]; run[i] = 0; end
        else run[i]++;
      end else run[i] = 0;
      void'(hist[i].pop_front());
      hist[i].push_back(raw[i]);
    end
    for (int i = 0; i < 2; i++) acc_ch[i] = (lvl1[i] != lvl2[i]) && (lvl[i] != ok[i]);
    ia = cfg_swap ? 1 : 0; ib = 1 - ia;
    now = cfg_tb_sel ? m_t1 : m_t0;
    case (cfg_home_mode)
      2'b00: hev = (lvl[2] == 1 && lvl1[2] == 0);
      2'b01: hev = (lvl[2] == 0 && lvl1[2] == 1);
      default: hev = (lvl[2] != lvl1[2]);
    endcase
    if (cmd_get_time) begin m_snap_e = m_last; m_snap_n = now; end
    if (pos_wr) m_pos = int'(wr_data);
    else if (cmd_init || hev) m_pos = m_preset;
    else if (acc_ch[ia] && !acc_ch[ib]) m_pos += (lvl[ia] != ok[ib]) ? 1 : -1;
    else if (acc_ch[ib] && !acc_ch[ia]) m_pos += (lvl[ib] == ok[ia]) ? 1 : -1;
    if (acc_ch[0] != acc_ch[1]) m_last = now;
    if (hev) m_flag = 1; else if (status_clr) m_flag = 0;
    if (acc_ch[0] && acc_ch[1]) m_err = 1; else if (status_clr) m_err = 0;
    if (preset_wr) m_preset = int'(wr_data);
    for (int i = 0; i < 2; i++) if (acc_ch[i]) ok[i] = lvl[i];
    for (int i = 0; i < 3; i++) begin lvl2[i] = lvl1[i]; lvl1[i] = lvl[i]; lvl[i] = nlvl[i]; end
    m_t0 = (m_t0 + 1) % 65536;
    if (m_div == TB1_DIV - 1) begin m_div = 0; m_t1 = (m_t1 + 1) % 65536; end
    else m_div++;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(req, "pos", pos, longint'(unsigned'(m_pos)));
    chk(req, "last_edge_ts", last_edge_ts, m_last);
    chk(req, "snap_edge_ts", snap_edge_ts, m_snap_e);
    chk(req, "snap_now_ts", snap_now_ts, m_snap_n);
    chk(req, "home_flag", home_flag, m_flag);
    chk(req, "phase_err", phase_err, m_err);
    chk(req, "irq", irq, m_flag & cfg_irq_en);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic set_q();
    in_p0 = (qs == 1 || qs == 2); in_p1 = (qs >= 2);
    ticks(6);
  endtask
  task automatic fwd(int n); for (int k = 0; k < n; k++) begin qs = (qs + 1) % 4; set_q(); end endtask
  task automatic rev(int n); for (int k = 0; k < n; k++) begin qs = (qs + 3) % 4; set_q(); end endtask

  task automatic pulse_p0(int w);
    in_p0 = 1; ticks(w); in_p0 = 0; ticks(12);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R12", "reset pos", pos, 0);
    chk("R12", "reset flags", {home_flag, phase_err, irq}, 0);
    chk("R12", "reset ts", {last_edge_ts, snap_edge_ts, snap_now_ts}, 0);
    ticks(4);

    req = "R1"; fwd(16);
    chk("R1", "forward 16 edges", pos, 16);
    rev(8);
    chk("R1", "reverse 8 edges", pos, 8);

    req = "R2"; cfg_swap = 1; ticks(2); fwd(8);
    chk("R2", "swapped roles count down", pos, 0);
    cfg_swap = 0; ticks(2);

    req = "R3"; wr_data = 1000; preset_wr = 1; tick(); preset_wr = 0; ticks(2);
    chk("R3", "preset alone leaves pos", pos, 0);
    cmd_init = 1; tick(); cmd_init = 0;
    chk("R3", "init from preset", pos, 1000);
    wr_data = 32'hFFFF_FFFB; preset_wr = 1; tick(); preset_wr = 0;
    cmd_init = 1; tick(); cmd_init = 0;
    chk("R3", "init negative preset", pos, 32'hFFFF_FFFB);

    req = "R4"; cfg_filt_len = 4'd3; ticks(2);
    pulse_p0(3);
    chk("R4", "3-cycle pulse filtered out", pos, 32'hFFFF_FFFB);
    in_p0 = 1; ticks(12);
    chk("R4", "held level counted", pos, 32'hFFFF_FFFC);
    in_p0 = 0; ticks(12);
    chk("R4", "release counted down", pos, 32'hFFFF_FFFB);
    pulse_p0(4);
    chk("R4", "4-cycle pulse net zero", pos, 32'hFFFF_FFFB);
    cfg_filt_len = 4'd0; ticks(2);

    req = "R5"; pulse_p0(1);
    chk("R5", "1-cycle pulse no count", pos, 32'hFFFF_FFFB);
    pulse_p0(2);
    chk("R5", "2-cycle pulse net zero", pos, 32'hFFFF_FFFB);

    req = "R6"; in_p0 = 1; in_p1 = 1; ticks(8);
    chk("R6", "both change pos held", pos, 32'hFFFF_FFFB);
    chk("R6", "both change error set", phase_err, 1);
    ticks(3);
    chk("R6", "error sticky", phase_err, 1);
    status_clr = 1; tick(); status_clr = 0;
    chk("R6", "error cleared", phase_err, 0);
    in_p0 = 0; in_p1 = 0; ticks(8); status_clr = 1; tick(); status_clr = 0; qs = 0;

    req = "R7"; cfg_tb_sel = 0; fwd(2); cfg_tb_sel = 1; fwd(2); rev(1);
    chk("R7", "counts around stamps", pos, 32'hFFFF_FFFE);

    req = "R8"; ticks(5); cmd_get_time = 1; tick(); cmd_get_time = 0;
    chk("R8", "snap edge equals last edge", snap_edge_ts, last_edge_ts);
    cfg_tb_sel = 0; cmd_get_time = 1; tick(); cmd_get_time = 0;

    req = "R9"; wr_data = 50; preset_wr = 1; tick(); preset_wr = 0;
    cfg_irq_en = 1; cfg_home_mode = 2'b00; in_home = 1; ticks(8);
    chk("R9", "rising home reload", pos, 50);
    chk("R10", "irq raised", irq, 1);
    fwd(1); in_home = 0; ticks(8);
    chk("R9", "falling ignored in rise mode", pos, 51);
    status_clr = 1; tick(); status_clr = 0;
    chk("R10", "flag cleared", home_flag, 0);
    cfg_home_mode = 2'b01; in_home = 1; ticks(8);
    chk("R9", "rising ignored in fall mode", pos, 51);
    in_home = 0; ticks(8);
    chk("R9", "falling home reload", pos, 50);
    status_clr = 1; tick(); status_clr = 0;
    cfg_home_mode = 2'b10; cfg_irq_en = 0; fwd(1); in_home = 1; ticks(8);
    chk("R9", "any-edge rise reload", pos, 50);
    chk("R10", "flag set with irq off", home_flag, 1);
    chk("R10", "irq masked", irq, 0);
    fwd(1); in_home = 0; ticks(8);
    chk("R9", "any-edge fall reload", pos, 50);
    status_clr = 1; tick(); status_clr = 0;

    req = "R11"; wr_data = 777; pos_wr = 1; cmd_init = 1; tick(); pos_wr = 0; cmd_init = 0;
    chk("R11", "write beats init", pos, 777);
    qs = (qs + 1) % 4; in_p0 = (qs == 1 || qs == 2); in_p1 = (qs >= 2); tick();
    in_home = 1; ticks(10);
    chk("R11", "home beats count same edge", pos, 50);
    wr_data = 9; fwd(1); pos_wr = 1; tick(); pos_wr = 0;
    chk("R11", "write after count", pos, 9);
    ticks(6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL %s watchdog expired", req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule